// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Logic

This block keeps the status flags and produces the interrupt request for one channel of an asynchronous serial port. The receive datapath sends it single-cycle pulses. It reports that a byte has arrived, and with that pulse it gives the parity result and the sampled stop bit. The transmit side sends two strobes: one when software writes the holding register, and one when the shifter takes a byte from it. From these events the block keeps receive-full, overrun, parity-error, framing-error and transmit-empty flags. It combines them with two enables into a single interrupt line.

Two pins from outside the chip are also inputs. A clear-to-send pin is shared with the receive line of a clocked serial port. A control bit selects which function uses the pin. When the pin carries clear-to-send and is high, the transmit-empty flag reads 0. A carrier-detect pin passes through a synchronizer. While it is high it keeps the receive error flags cleared. Its rising edge is latched as a receive interrupt source, which stays pending until software reads carrier-detect or clears the error flags. An I/O-stop mode input clears the receive flags and marks the transmit side empty.

Software reads the flags as one status byte. It writes the same byte to set the three enable bits.

Top module: `scs_status_top`

## Requirements
- R1: After reset the status byte is 8'h02 (only transmit-empty set), the interrupt output is 0 and the pin-function select output is 1.
- R2: A control write updates only status bits 3 (receive interrupt enable), 2 (clear-to-send enable) and 0 (transmit interrupt enable). Writing 1 to bits 7..4 or bit 1 changes nothing.
- R3: A receive-done pulse sets bit 7 (receive full). A data-read strobe clears it. If both arrive in the same cycle, bit 7 ends at 1 and no overrun is recorded.
- R4: A receive-done pulse while bit 7 is already 1, with no read in that cycle, sets bit 6 (overrun).
- R5: With a receive-done pulse, a parity-error input of 1 sets bit 5, and a stop-bit input of 0 sets bit 4 (framing error). A stop bit of 1 leaves bit 4 at 0.
- R6: Bits 6..4 clear on the error-clear strobe, while synchronized carrier-detect is high, and in I/O-stop mode. Clearing takes priority over setting. The error-clear strobe leaves bit 7 unchanged. I/O-stop also clears bit 7.
- R7: A holding-register write clears transmit-empty (bit 1). A shifter-load strobe sets it. If both arrive in the same cycle, the write wins.
- R8: I/O-stop mode sets the internal transmit-empty state to 1.
- R9: When clear-to-send is enabled (bit 2 = 1) and the synchronized clear-to-send pin is high, bit 1 reads 0. When bit 2 = 0, the pin has no effect.
- R10: The interrupt output is 1 when bit 3 is 1 and any of bits 7..4, or a latched carrier-detect edge, is 1.
- R11: The interrupt output is 1 when bits 0 and 1 are both 1.
- R12: A low-to-high transition of the synchronized carrier-detect pin latches an edge event. The event clears on a carrier-detect read strobe or on the error-clear strobe.
- R13: The pin-function select output is the inverse of bit 2 (1 selects the clocked serial port's receive function).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iostop_i | input | 1 | I/O-stop mode |
| rx_done_i | input | 1 | Pulse: a receive byte completed |
| rx_perr_i | input | 1 | Parity error of the completed byte, valid with rx_done_i |
| rx_stop_i | input | 1 | Sampled stop bit of the completed byte, valid with rx_done_i |
| rdr_rd_i | input | 1 | Pulse: receive data register read |
| tdr_wr_i | input | 1 | Pulse: transmit holding register written |
| tsr_load_i | input | 1 | Pulse: transmit shifter loaded from holding register |
| cts_pin_i | input | 1 | Shared clear-to-send pin, high means deasserted (asynchronous) |
| dcd_pin_i | input | 1 | Carrier-detect pin, high means no carrier (asynchronous) |
| dcd_rd_i | input | 1 | Pulse: software read of carrier-detect |
| efr_clr_i | input | 1 | Pulse: error-flag-reset control bit written with 0 |
| ctl_wr_i | input | 1 | Pulse: status/control byte written |
| ctl_wdata_i | input | 8 | Data of the control write |
| status_o | output | 8 | Status byte |
| rxs_sel_o | output | 1 | 1 = shared pin used as clocked-port receive data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Each flag source is tried alone, then in colliding pairs in the same cycle: read with receive-done, write with shifter-load, and a set with a clear. The collisions show which priority the logic applies, which single events cannot show. The interrupt is driven by each source with its enable off and then on. This tells the gating apart from the flag. The two pins are changed with their enables on and off, and are sampled only after the synchronizer delay. This separates the pin's effect from the control bit that enables it. Carrier-detect edges are raised twice and cleared each time by a different strobe, once by a carrier-detect read and once by the error-clear strobe.

// File: rtl/scs_pkg.sv
package scs_pkg;
    // Bit positions of the status byte (software decodes these)
    localparam int unsigned ST_RDF  = 7;
    localparam int unsigned ST_OVR  = 6;
    localparam int unsigned ST_PE   = 5;
    localparam int unsigned ST_FE   = 4;
    localparam int unsigned ST_RIE  = 3;
    localparam int unsigned ST_CTSE = 2;
    localparam int unsigned ST_TDRE = 1;
    localparam int unsigned ST_TIE  = 0;
    localparam int unsigned ST_W    = 8;

    typedef struct packed {
        logic rdf;
        logic ovr;
        logic pe;
        logic fe;
        logic dcd_evt;
    } rx_state_t;

    typedef struct packed {
        logic rie;
        logic ctse;
        logic tie;
    } ctl_state_t;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] chain;
        logic          prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_i;
        for (int unsigned i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.chain[LAST];
    assign rise_o  = s_q.chain[LAST] & ~s_q.prev;
endmodule

// File: rtl/scs_rxflags.sv
module scs_rxflags
    import scs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_done_i,
    input  logic      rx_perr_i,
    input  logic      rx_stop_i,
    input  logic      rdr_rd_i,
    input  logic      err_clr_i,
    input  logic      iostop_i,
    input  logic      dcd_rise_i,
    input  logic      dcd_rd_i,
    input  logic      efr_clr_i,
    output rx_state_t rx_o
);
    rx_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // receive full: read clears, new byte sets (set wins)
        if (rdr_rd_i)  r_d.rdf = 1'b0;
        if (rx_done_i) r_d.rdf = 1'b1;
        if (rx_done_i) begin
            if (r_q.rdf && !rdr_rd_i) r_d.ovr = 1'b1;
            if (rx_perr_i)            r_d.pe  = 1'b1;
            if (!rx_stop_i)           r_d.fe  = 1'b1;
        end
        // error clearing has priority over any set
        if (err_clr_i) begin
            r_d.ovr = 1'b0;
            r_d.pe  = 1'b0;
            r_d.fe  = 1'b0;
        end
        if (iostop_i) r_d.rdf = 1'b0;
        // carrier-detect edge event
        if (dcd_rd_i || efr_clr_i) r_d.dcd_evt = 1'b0;
        if (dcd_rise_i)            r_d.dcd_evt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_o = r_q;
endmodule

// File: rtl/scs_txflag.sv
module scs_txflag (
    input  logic clk,
    input  logic rst_n,
    input  logic tdr_wr_i,
    input  logic tsr_load_i,
    input  logic iostop_i,
    input  logic cts_block_i,
    output logic tdre_o
);
    typedef struct packed {
        logic empty;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (tsr_load_i) t_d.empty = 1'b1;
        if (tdr_wr_i)   t_d.empty = 1'b0;
        if (iostop_i)   t_d.empty = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '{empty: 1'b1};
        else        t_q <= t_d;
    end

    assign tdre_o = t_q.empty & ~cts_block_i;
endmodule

// File: rtl/scs_status_top.sv
module scs_status_top
    import scs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iostop_i,
    input  logic       rx_done_i,
    input  logic       rx_perr_i,
    input  logic       rx_stop_i,
    input  logic       rdr_rd_i,
    input  logic       tdr_wr_i,
    input  logic       tsr_load_i,
    input  logic       cts_pin_i,
    input  logic       dcd_pin_i,
    input  logic       dcd_rd_i,
    input  logic       efr_clr_i,
    input  logic       ctl_wr_i,
    input  logic [7:0] ctl_wdata_i,
    output logic [7:0] status_o,
    output logic       rxs_sel_o,
    output logic       irq_o
);
    ctl_state_t c_d, c_q;
    rx_state_t  rx;
    logic       cts_lvl, cts_rise_unused;
    logic       dcd_lvl, dcd_rise;
    logic       tdre;
    logic       err_clr;
    logic       rx_irq, tx_irq;
    logic       unused_wbits;

    assign unused_wbits = ^{ctl_wdata_i[7:4], ctl_wdata_i[1]};

    scs_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk(clk), .rst_n(rst_n), .async_i(cts_pin_i),
        .level_o(cts_lvl), .rise_o(cts_rise_unused)
    );

    scs_sync #(.STAGES(SYNC_STAGES)) u_dcd_sync (
        .clk(clk), .rst_n(rst_n), .async_i(dcd_pin_i),
        .level_o(dcd_lvl), .rise_o(dcd_rise)
    );

    assign err_clr = efr_clr_i | dcd_lvl | iostop_i;

    scs_rxflags u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_done_i(rx_done_i), .rx_perr_i(rx_perr_i), .rx_stop_i(rx_stop_i),
        .rdr_rd_i(rdr_rd_i), .err_clr_i(err_clr), .iostop_i(iostop_i),
        .dcd_rise_i(dcd_rise), .dcd_rd_i(dcd_rd_i), .efr_clr_i(efr_clr_i),
        .rx_o(rx)
    );

    scs_txflag u_tx (
        .clk(clk), .rst_n(rst_n),
        .tdr_wr_i(tdr_wr_i), .tsr_load_i(tsr_load_i), .iostop_i(iostop_i),
        .cts_block_i(c_q.ctse & cts_lvl),
        .tdre_o(tdre)
    );

    always_comb begin
        c_d = c_q;
        if (ctl_wr_i) begin
            c_d.rie  = ctl_wdata_i[ST_RIE];
            c_d.ctse = ctl_wdata_i[ST_CTSE];
            c_d.tie  = ctl_wdata_i[ST_TIE];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        status_o          = '0;
        status_o[ST_RDF]  = rx.rdf;
        status_o[ST_OVR]  = rx.ovr;
        status_o[ST_PE]   = rx.pe;
        status_o[ST_FE]   = rx.fe;
        status_o[ST_RIE]  = c_q.rie;
        status_o[ST_CTSE] = c_q.ctse;
        status_o[ST_TDRE] = tdre;
        status_o[ST_TIE]  = c_q.tie;
    end

    assign rx_irq    = c_q.rie & (rx.rdf | rx.ovr | rx.pe | rx.fe | rx.dcd_evt);
    assign tx_irq    = c_q.tie & tdre;
    assign irq_o     = rx_irq | tx_irq;
    assign rxs_sel_o = ~c_q.ctse;
endmodule

// File: rtl/scs_status_chk.sv
module scs_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iostop_i,
    input logic       rx_done_i,
    input logic       rdr_rd_i,
    input logic       tdr_wr_i,
    input logic       efr_clr_i,
    input logic       ctl_wr_i,
    input logic [7:0] status_o,
    input logic       rxs_sel_o,
    input logic       irq_o
);
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rdr_rd_i && !rx_done_i) |=> !status_o[7]);

    a_r6_efr_clears_errors: assert property (@(posedge clk) disable iff (!rst_n)
        efr_clr_i |=> (status_o[6:4] == 3'b000));

    a_r7_write_clears_tdre: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_wr_i && !iostop_i) |=> !status_o[1]);

    a_r8_iostop_sets_tdre: assert property (@(posedge clk) disable iff (!rst_n)
        (iostop_i && !status_o[2] && !ctl_wr_i) |=> status_o[1]);

    a_r10_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3] && (status_o[7:4] != 4'b0000)) |-> irq_o);

    a_r11_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && status_o[1]) |-> irq_o);

    a_r13_pin_select: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr_i) |-> (rxs_sel_o == !status_o[2]));
endmodule

bind scs_status_top scs_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .iostop_i(iostop_i), .rx_done_i(rx_done_i),
    .rdr_rd_i(rdr_rd_i), .tdr_wr_i(tdr_wr_i), .efr_clr_i(efr_clr_i),
    .ctl_wr_i(ctl_wr_i), .status_o(status_o), .rxs_sel_o(rxs_sel_o),
    .irq_o(irq_o)
);

// File: tb/scs_status_top_bench.sv
module scs_status_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iostop_i = 0, rx_done_i = 0, rx_perr_i = 0, rx_stop_i = 1;
    logic       rdr_rd_i = 0, tdr_wr_i = 0, tsr_load_i = 0;
    logic       cts_pin_i = 0, dcd_pin_i = 0, dcd_rd_i = 0, efr_clr_i = 0;
    logic       ctl_wr_i = 0;
    logic [7:0] ctl_wdata_i = 8'h00;
    logic [7:0] status_o;
    logic       rxs_sel_o, irq_o;
    int         n_chk = 0, n_fail = 0, cyc = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    scs_status_top u_scs_status_top (
        .clk(clk), .rst_n(rst_n), .iostop_i(iostop_i), .rx_done_i(rx_done_i),
        .rx_perr_i(rx_perr_i), .rx_stop_i(rx_stop_i), .rdr_rd_i(rdr_rd_i),
        .tdr_wr_i(tdr_wr_i), .tsr_load_i(tsr_load_i), .cts_pin_i(cts_pin_i),
        .dcd_pin_i(dcd_pin_i), .dcd_rd_i(dcd_rd_i), .efr_clr_i(efr_clr_i),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .status_o(status_o),
        .rxs_sel_o(rxs_sel_o), .irq_o(irq_o)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(logic [7:0] v);
        ctl_wr_i = 1; ctl_wdata_i = v; @(negedge clk); ctl_wr_i = 0;
    endtask

    task automatic rxb(logic perr, logic stopb);
        rx_done_i = 1; rx_perr_i = perr; rx_stop_i = stopb;
        @(negedge clk);
        rx_done_i = 0; rx_perr_i = 0; rx_stop_i = 1;
    endtask

    task automatic rd();
        rdr_rd_i = 1; @(negedge clk); rdr_rd_i = 0;
    endtask

    task automatic efr();
        efr_clr_i = 1; @(negedge clk); efr_clr_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 8'h02);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        chk("R13 rxs_sel", {7'b0, rxs_sel_o}, 8'h01);
    endtask

    task automatic t_ctl();
        ctl(8'hFF);
        chk("R2 write all ones", status_o, 8'h0F);
        chk("R11 tx irq", {7'b0, irq_o}, 8'h01);
        chk("R13 rxs_sel", {7'b0, rxs_sel_o}, 8'h00);
        ctl(8'h00);
        chk("R2 write zero", status_o, 8'h02);
        chk("R11 tie off", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_rx();
        rxb(0, 1);
        chk("R3 rdf set", status_o, 8'h82);
        rxb(0, 1);
        chk("R4 overrun", status_o, 8'hC2);
        rd();
        chk("R3 read clears rdf", status_o, 8'h42);
        efr();
        chk("R6 efr clears ovr", status_o, 8'h02);
        rxb(1, 0);
        chk("R5 pe and fe", status_o, 8'hB2);
        chk("R10 rie off no irq", {7'b0, irq_o}, 8'h00);
        ctl(8'h08);
        chk("R10 rx irq", {7'b0, irq_o}, 8'h01);
        efr();
        chk("R6 efr keeps rdf", status_o, 8'h8A);
        rd();
        chk("R10 no source", {7'b0, irq_o}, 8'h00);
        // same-cycle read and receive
        rxb(0, 1);
        rdr_rd_i = 1; rx_done_i = 1; @(negedge clk); rdr_rd_i = 0; rx_done_i = 0;
        chk("R3 read+done", status_o, 8'h8A);
        rxb(1, 1);
        chk("R5 stop ok no fe", status_o[5:4], 8'h02);
        iostop_i = 1; @(negedge clk); iostop_i = 0;
        chk("R6 iostop clears", status_o, 8'h0A);
        ctl(8'h00);
    endtask

    task automatic t_tx();
        tdr_wr_i = 1; @(negedge clk); tdr_wr_i = 0;
        chk("R7 write clears", status_o, 8'h00);
        tsr_load_i = 1; @(negedge clk); tsr_load_i = 0;
        chk("R7 load sets", status_o, 8'h02);
        tdr_wr_i = 1; tsr_load_i = 1; @(negedge clk); tdr_wr_i = 0; tsr_load_i = 0;
        chk("R7 write wins", status_o, 8'h00);
        iostop_i = 1; @(negedge clk); iostop_i = 0;
        chk("R8 iostop sets", status_o, 8'h02);
    endtask

    task automatic t_cts();
        cts_pin_i = 1; idle(3);
        chk("R9 pin ignored when disabled", status_o, 8'h02);
        ctl(8'h05);
        chk("R9 blocked", status_o, 8'h05);
        chk("R11 no irq while blocked", {7'b0, irq_o}, 8'h00);
        cts_pin_i = 0; idle(3);
        chk("R9 released", status_o, 8'h07);
        chk("R11 irq", {7'b0, irq_o}, 8'h01);
        cts_pin_i = 1; ctl(8'h00);
        chk("R13 rxs_sel back", {7'b0, rxs_sel_o}, 8'h01);
        cts_pin_i = 0; idle(3);
    endtask

    task automatic t_dcd();
        dcd_pin_i = 1; idle(4);
        chk("R12 latched, rie off", {7'b0, irq_o}, 8'h00);
        ctl(8'h08);
        chk("R12 edge irq", {7'b0, irq_o}, 8'h01);
        rxb(1, 0);
        chk("R6 dcd high holds errors clear", status_o, 8'h8A);
        rd();
        dcd_rd_i = 1; @(negedge clk); dcd_rd_i = 0;
        chk("R12 dcd read clears", {7'b0, irq_o}, 8'h00);
        dcd_pin_i = 0; idle(4);
        dcd_pin_i = 1; idle(4);
        chk("R12 second edge", {7'b0, irq_o}, 8'h01);
        efr();
        chk("R12 efr clears event", {7'b0, irq_o}, 8'h00);
        dcd_pin_i = 0; idle(4);
        ctl(8'h00);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_rx();
        t_tx();
        t_cts();
        t_dcd();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule